// File: doc/BRIEF.md
# Floating-Point Load/Store Effective-Address Generator

This block forms the memory address for floating-point loads and stores and decides whether the base register must be rewritten with that address afterwards. Each request carries an addressing form, a 16-bit signed displacement, the base-register index, the base and index register values, and a flag that marks the store-as-integer-word instruction. One cycle later the block presents the effective address together with an illegal-request flag. Its sizes are parameters. The defaults are a 32-bit address, a 16-bit displacement and a 5-bit register index.

For the two update forms, the block holds the pending base-register write. It releases that write only when the pipeline reports that the operation finished without an enabled exception trap. A trapped completion drops the pending write. Address arithmetic wraps modulo 2^32. The memory access and the register file sit outside this block.

Top module: `fpls_agu`

## Requirements
- R1: A request sampled with `req_valid` high produces exactly one `addr_valid` pulse on the following clock edge. No pulse appears without a request.
- R2: Form code 2'b00 (displacement) yields the sign-extended displacement plus the base value. When the base index is 0, the base is taken as zero.
- R3: Form code 2'b01 (displacement with update) with base index 0 is illegal. Otherwise it yields the base value plus the sign-extended displacement, and it arms a write-back of that address to the base index.
- R4: Form code 2'b10 (indexed) with base index not 0 yields the base value plus the index value.
- R5: Form code 2'b10 with base index 0 yields the index value alone when `sel_siw` is 1. When `sel_siw` is 0, the request is illegal.
- R6: Form code 2'b11 (indexed with update) yields the index value plus either the base value or zero when the base index is 0. It arms a write-back of that address to the base index, including index 0.
- R7: An illegal request reports `illegal`=1 with `addr`=0 and arms no write-back.
- R8: A completion (`done_valid`) with `done_trap`=0 fires `wb_en` for one cycle on the next edge, carrying the armed index and address. A completion with `done_trap`=1 drops the armed write, and `wb_en` stays 0.
- R9: A request in a non-update form cancels any write-back still armed from an earlier request, so a later completion writes nothing.
- R10: All address sums wrap modulo 2^AW.
- R11: While reset is asserted, and on the first cycles after it, `addr_valid` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| form | input | 2 | Addressing form: 00 disp, 01 disp-update, 10 indexed, 11 indexed-update |
| sel_siw | input | 1 | Request is the store-as-integer-word instruction |
| disp | input | 16 | Signed displacement |
| ra_idx | input | 5 | Base register index |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| done_valid | input | 1 | Operation completion strobe |
| done_trap | input | 1 | Completion raised an enabled exception trap |
| addr_valid | output | 1 | Effective address valid |
| addr | output | 32 | Effective address |
| illegal | output | 1 | Request is illegal |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
The address, `addr_valid` and `illegal` appear one edge after the request. The bench therefore pushes each expectation when it drives a request on a falling edge. Its monitor pops and compares on every later falling edge where `addr_valid` is high. The write-back result is due one edge after the completion strobe, so the bench drives `done_valid` on a falling edge and samples `wb_en`, `wb_idx` and `wb_data` on the next falling edge. Leftover expectations at the end count as miscompares.

// File: rtl/fpls_agu_pkg.sv
package fpls_agu_pkg;
  typedef enum logic [1:0] {
    FORM_DISP     = 2'b00,
    FORM_DISP_UPD = 2'b01,
    FORM_IDX      = 2'b10,
    FORM_IDX_UPD  = 2'b11
  } form_e;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import fpls_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int IW = 5
) (
  input  form_e          form,
  input  logic           sel_siw,
  input  logic [DW-1:0]  disp,
  input  logic [IW-1:0]  ra_idx,
  input  logic [AW-1:0]  ra_val,
  input  logic [AW-1:0]  rb_val,
  output logic [AW-1:0]  base,
  output logic [AW-1:0]  offset,
  output logic           is_upd,
  output logic           bad
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] disp_ext;
  logic          ra_zero;

  assign disp_ext = {{EXT{disp[DW-1]}}, disp};
  assign ra_zero  = (ra_idx == '0);

  always_comb begin
    base   = '0;
    offset = disp_ext;
    is_upd = 1'b0;
    bad    = 1'b0;
    unique case (form)
      FORM_DISP: begin
        if (!ra_zero) base = ra_val;
      end
      FORM_DISP_UPD: begin
        if (ra_zero) begin
          bad = 1'b1;
        end else begin
          base   = ra_val;
          is_upd = 1'b1;
        end
      end
      FORM_IDX: begin
        offset = rb_val;
        if (!ra_zero)      base = ra_val;
        else if (!sel_siw) bad  = 1'b1;
      end
      FORM_IDX_UPD: begin
        offset = rb_val;
        is_upd = 1'b1;
        if (!ra_zero) base = ra_val;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);
  // Carry out is discarded: modulo 2^AW wrap.
  logic [AW:0] full;
  assign full = {1'b0, a} + {1'b0, b};
  assign sum  = full[AW-1:0];
endmodule

// File: rtl/agu_wb_hold.sv
module agu_wb_hold #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ld_upd,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_addr,
  input  logic          done_valid,
  input  logic          done_trap,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  logic          pend_q, pend_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [AW-1:0] data_q, data_n;
  logic          fire_q, fire_n;
  logic [IW-1:0] oidx_q;
  logic [AW-1:0] odata_q;

  always_comb begin
    pend_n = pend_q;
    idx_n  = idx_q;
    data_n = data_q;
    fire_n = done_valid & ~done_trap & pend_q;
    if (done_valid) pend_n = 1'b0;
    if (ld) begin
      pend_n = ld_upd;
      idx_n  = ld_idx;
      data_n = ld_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      fire_q <= fire_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      idx_q  <= idx_n;
      data_q <= data_n;
    end
    if (fire_n) begin
      oidx_q  <= idx_q;
      odata_q <= data_q;
    end
  end

  assign wb_en   = fire_q;
  assign wb_idx  = oidx_q;
  assign wb_data = odata_q;
endmodule

// File: rtl/fpls_agu.sv
module fpls_agu
  import fpls_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int IW = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    form,
  input  logic          sel_siw,
  input  logic [DW-1:0] disp,
  input  logic [IW-1:0] ra_idx,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  input  logic          done_valid,
  input  logic          done_trap,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          illegal,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  logic [AW-1:0] base, offset, sum;
  logic          is_upd, bad;

  agu_decode #(.AW(AW), .DW(DW), .IW(IW)) u_dec (
    .form    (form_e'(form)),
    .sel_siw (sel_siw),
    .disp    (disp),
    .ra_idx  (ra_idx),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .base    (base),
    .offset  (offset),
    .is_upd  (is_upd),
    .bad     (bad)
  );

  agu_adder #(.AW(AW)) u_add (
    .a   (base),
    .b   (offset),
    .sum (sum)
  );

  // Result stage
  logic          vld_q, vld_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          ill_q, ill_n;

  always_comb begin
    vld_n  = req_valid;
    addr_n = bad ? '0 : sum;
    ill_n  = bad;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) vld_q <= 1'b0;
    else         vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      addr_q <= addr_n;
      ill_q  <= ill_n;
    end
  end

  assign addr_valid = vld_q;
  assign addr       = addr_q;
  assign illegal    = ill_q;

  agu_wb_hold #(.AW(AW), .IW(IW)) u_wb (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ld         (req_valid),
    .ld_upd     (is_upd & ~bad),
    .ld_idx     (ra_idx),
    .ld_addr    (sum),
    .done_valid (done_valid),
    .done_trap  (done_trap),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data)
  );
endmodule

// File: rtl/fpls_agu_chk.sv
module fpls_agu_chk #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    form,
  input logic [IW-1:0] ra_idx,
  input logic          done_valid,
  input logic          done_trap,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          illegal,
  input logic          wb_en
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);

  a_r3_upd_ra0_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && form == 2'b01 && ra_idx == '0) |=> (addr_valid && illegal));

  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && illegal) |-> (addr == '0));

  a_r8_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(done_valid && !done_trap));
endmodule

bind fpls_agu fpls_agu_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .req_valid  (req_valid),
  .form       (form),
  .ra_idx     (ra_idx),
  .done_valid (done_valid),
  .done_trap  (done_trap),
  .addr_valid (addr_valid),
  .addr       (addr),
  .illegal    (illegal),
  .wb_en      (wb_en)
);

// File: tb/tb_fpls_agu.sv
`timescale 1ns/1ps
module tb_fpls_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  form = 2'b00;
  logic        sel_siw = 1'b0;
  logic [15:0] disp = '0;
  logic [4:0]  ra_idx = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] rb_val = '0;
  logic        done_valid = 1'b0;
  logic        done_trap = 1'b0;
  logic        addr_valid;
  logic [31:0] addr;
  logic        illegal;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  always #10 clk = ~clk;

  fpls_agu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .form(form),
    .sel_siw(sel_siw), .disp(disp), .ra_idx(ra_idx), .ra_val(ra_val),
    .rb_val(rb_val), .done_valid(done_valid), .done_trap(done_trap),
    .addr_valid(addr_valid), .addr(addr), .illegal(illegal),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  typedef struct {
    logic [31:0] a;
    logic        ill;
    string       req;
  } exp_t;

  exp_t q[$];
  int   nvec = 0;
  int   nmis = 0;
  bit   finished = 1'b0;

  // Reference computed from the requirements.
  function automatic void model(input logic [1:0] f, input logic s,
                                input logic [15:0] d, input logic [4:0] ri,
                                input logic [31:0] rv, input logic [31:0] bv,
                                output logic [31:0] a, output logic ill,
                                output logic upd);
    logic [31:0] dx;
    logic [31:0] bs;
    dx  = {{16{d[15]}}, d};
    bs  = (ri == 0) ? 32'd0 : rv;
    ill = 1'b0;
    upd = 1'b0;
    a   = 32'd0;
    case (f)
      2'b00: a = bs + dx;
      2'b01: if (ri == 0) ill = 1'b1; else begin a = rv + dx; upd = 1'b1; end
      2'b10: if (ri != 0) a = rv + bv; else if (s) a = bv; else ill = 1'b1;
      default: begin a = bs + bv; upd = 1'b1; end
    endcase
  endfunction

  task automatic issue(input logic [1:0] f, input logic s, input logic [15:0] d,
                       input logic [4:0] ri, input logic [31:0] rv,
                       input logic [31:0] bv, input string req);
    exp_t e;
    logic u;
    @(negedge clk);
    form = f; sel_siw = s; disp = d; ra_idx = ri; ra_val = rv; rb_val = bv;
    req_valid = 1'b1;
    model(f, s, d, ri, rv, bv, e.a, e.ill, u);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic trap, input logic exp_en,
                          input logic [4:0] exp_idx, input logic [31:0] exp_data,
                          input string req);
    @(negedge clk);
    done_valid = 1'b1;
    done_trap = trap;
    @(negedge clk);
    done_valid = 1'b0;
    done_trap = 1'b0;
    nvec++;
    if (wb_en !== exp_en ||
        (exp_en && (wb_idx !== exp_idx || wb_data !== exp_data))) begin
      nmis++;
      $display("FAIL %s wb: en=%0b idx=%0d data=%h expected en=%0b idx=%0d data=%h",
               req, wb_en, wb_idx, wb_data, exp_en, exp_idx, exp_data);
    end
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (rst_n && addr_valid) begin
      nvec++;
      if (q.size() == 0) begin
        nmis++;
        $display("FAIL R1 unexpected addr_valid: addr=%h expected no result", addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (addr !== e.a || illegal !== e.ill) begin
          nmis++;
          $display("FAIL %s addr=%h illegal=%0b expected addr=%h illegal=%0b",
                   e.req, addr, illegal, e.a, e.ill);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    // R11: reset state
    nvec++;
    if (addr_valid !== 1'b0 || wb_en !== 1'b0) begin
      nmis++;
      $display("FAIL R11 addr_valid=%0b wb_en=%0b expected 0 0", addr_valid, wb_en);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    nvec++;
    if (addr_valid !== 1'b0 || wb_en !== 1'b0) begin
      nmis++;
      $display("FAIL R11 after release addr_valid=%0b wb_en=%0b expected 0 0",
               addr_valid, wb_en);
    end
    repeat (3) @(negedge clk);

    issue(2'b00, 1'b0, 16'h0010, 5'd3, 32'h0000_1000, 32'h0, "R2");
    issue(2'b00, 1'b0, 16'hFFF0, 5'd0, 32'hDEAD_BEEF, 32'h0, "R2 ra0");
    issue(2'b00, 1'b0, 16'h8000, 5'd7, 32'h0001_0000, 32'h0, "R2 negative");
    issue(2'b01, 1'b0, 16'h0004, 5'd0, 32'h1234_0000, 32'h0, "R3 ra0");
    issue(2'b10, 1'b0, 16'h0000, 5'd4, 32'h0000_2000, 32'h0000_0030, "R4");
    issue(2'b10, 1'b1, 16'h0000, 5'd0, 32'hFFFF_FFFF, 32'h0000_4444, "R5 siw");
    issue(2'b10, 1'b0, 16'h0000, 5'd0, 32'hFFFF_FFFF, 32'h0000_4444, "R5 R7 illegal");
    issue(2'b00, 1'b0, 16'h0002, 5'd9, 32'hFFFF_FFFF, 32'h0, "R10 wrap");
    issue(2'b10, 1'b0, 16'h0000, 5'd2, 32'h8000_0000, 32'h8000_0001, "R10 wrap idx");

    // R3: legal update, completes cleanly
    issue(2'b01, 1'b0, 16'hFFFC, 5'd6, 32'h0000_0100, 32'h0, "R3");
    complete(1'b0, 1'b1, 5'd6, 32'h0000_00FC, "R3 R8");
    // R8: trapped completion drops write-back
    issue(2'b11, 1'b0, 16'h0000, 5'd12, 32'h0000_1000, 32'h0000_0008, "R6");
    complete(1'b1, 1'b0, 5'd0, 32'h0, "R8 trap");
    complete(1'b0, 1'b0, 5'd0, 32'h0, "R8 dropped");
    // R6: indexed-update with base index 0 writes index 0
    issue(2'b11, 1'b0, 16'h0000, 5'd0, 32'h5555_5555, 32'h0000_0ABC, "R6 ra0");
    complete(1'b0, 1'b1, 5'd0, 32'h0000_0ABC, "R6 R8 ra0");
    // R9: a non-update request cancels the armed write
    issue(2'b01, 1'b0, 16'h0020, 5'd5, 32'h0000_0200, 32'h0, "R3 arm");
    issue(2'b00, 1'b0, 16'h0020, 5'd5, 32'h0000_0200, 32'h0, "R9 cancel");
    complete(1'b0, 1'b0, 5'd0, 32'h0, "R9");
    // R7: illegal update arms nothing
    issue(2'b01, 1'b0, 16'h0020, 5'd0, 32'h0000_0200, 32'h0, "R7 upd");
    complete(1'b0, 1'b0, 5'd0, 32'h0, "R7 no wb");

    // Mixed patterns, back to back
    x = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      issue(x[1:0], x[2], x[31:16], (x[7:5] == 0) ? 5'd0 : x[12:8],
            x ^ 32'h9E37_79B9, {x[15:0], x[31:16]}, "R2 R4 R5 R6 mixed");
    end

    repeat (3) @(negedge clk);
    nvec++;
    if (q.size() != 0) begin
      nmis++;
      $display("FAIL R1 %0d results missing, expected 0", q.size());
    end
    finish_run();
  end
endmodule